// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides, for every received CAN frame, whether the frame is kept. It looks at the 11-bit base identifier, the 18-bit identifier extension, the IDE bit and the RTR bit. It compares them against a bank of fourteen programmable filters. For an accepted frame it reports which of two receive queues takes the frame, and a match index that names the entry that hit. The receiver that assembles frames and the queues that store them sit outside this block.

Each filter has two 32-bit words and four configuration bits:
- enable;
- compare style (mask or exact list);
- width (one 32-bit entry, or 16-bit halves);
- target queue.

A filter therefore holds one, two or four match entries. The match index counts entries across the bank in filter order, so software can tell which entry hit. Configuration is written through a small write-only port. Writes to the filter state are taken only while a configure bit is set, and no frame is accepted during that time.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the configure bit is 1; all enable, style, width and queue bits and all filter words are 0; `res_valid`, `res_accept`, `res_fifo` and `res_index` are 0.
- R2: Write addresses are: 0 for the configure bit (data bit 0), 1 for the style vector, 2 for the width vector, 3 for the queue vector and 4 for the enable vector (bit f for filter f). Filter f's first word is at 32+2f and its second word at 33+2f. Address 0 is always writable. All other addresses are written only while the configure bit is 1, and are ignored otherwise. While the configure bit is 1, every frame is rejected.
- R3: A filter whose enable bit is 0 never matches.
- R4: Width 1 with style 0 (mask) forms a 32-bit compare word: base id in [31:21], extension in [20:3], IDE in [2], RTR in [1], and 0 in [0]. The first word is the identifier and the second word is the mask. Bits where the mask is 1 must be equal; bits where it is 0 are ignored; bit 0 is never compared.
- R5: Width 1 with style 1 (list) compares bits [31:1] of the frame word for equality with the first word (entry 0) and with the second word (entry 1).
- R6: Width 0 uses a 16-bit compare word: base id in [15:5], RTR in [4], IDE in [3], extension bits 17:15 in [2:0]. With style 0, entry 0 uses the first word, with its low half as the identifier and its high half as the mask. Entry 1 takes the same form from the second word.
- R7: Width 0 with style 1 gives four exact 16-bit entries, in this order: first word low half, first word high half, second word low half, second word high half.
- R8: The match index counts entries in filter order, so each filter's first entry is numbered after all entries of the filters below it. A filter contributes 1 entry (32-bit mask), 2 entries (32-bit list or 16-bit mask) or 4 entries (16-bit list); enabled or not, its entries are counted. When several entries hit, the lowest index wins. A rejected frame reports index 0 and queue 0.
- R9: `res_fifo` of an accepted frame equals the queue bit of the winning filter.
- R10: A result appears exactly one cycle after `frm_valid` is sampled high. `res_valid` is 0 in every cycle that follows a cycle without a frame, and `res_accept` is never 1 without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 6 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| frm_valid | input | 1 | Frame identifier present this cycle |
| frm_sid | input | 11 | Base identifier |
| frm_eid | input | 18 | Identifier extension |
| frm_ide | input | 1 | Extended-format flag |
| frm_rtr | input | 1 | Remote-request flag |
| res_valid | output | 1 | Result present |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Target receive queue |
| res_index | output | 8 | Match index of the winning entry |

## Verification
The bound checker watches, on every cycle, properties that hold for any configuration:
- one-cycle result timing;
- rejection while the configure bit is set;
- rejection when no filter is enabled;
- zero index and queue on a rejected frame;
- an index range that fits the bank.

Only the bench's scenarios can show that the right entry wins. They cover mask and list compares at both widths, priority between overlapping filters, queue routing, writes ignored outside configure mode, and disabled catch-all filters. The bench compares every cycle against a behavioural model of the bank.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ENTRIES_MAX = 4;

  typedef struct packed {
    logic [10:0] sid;
    logic [17:0] eid;
    logic        ide;
    logic        rtr;
  } frame_id_t;

  typedef enum logic {
    CMP_MASK = 1'b0,
    CMP_LIST = 1'b1
  } cmp_style_e;

  function automatic logic [WORD_W-1:0] pack_wide(frame_id_t f);
    return {f.sid, f.eid, f.ide, f.rtr, 1'b0};
  endfunction

  function automatic logic [HALF_W-1:0] pack_narrow(frame_id_t f);
    return {f.sid, f.rtr, f.ide, f.eid[17:15]};
  endfunction

  function automatic int unsigned entry_count(logic wide, logic list);
    if (wide) return list ? 2 : 1;
    return list ? 4 : 2;
  endfunction
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int unsigned NFILT  = 14,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [WORD_W-1:0]              wr_data,
  output logic                           cfg_q,
  output logic [NFILT-1:0]               style_q,
  output logic [NFILT-1:0]               wide_q,
  output logic [NFILT-1:0]               queue_q,
  output logic [NFILT-1:0]               enable_q,
  output logic [NFILT-1:0][WORD_W-1:0]   w1_q,
  output logic [NFILT-1:0][WORD_W-1:0]   w2_q
);
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_STYLE  = 1;
  localparam int unsigned A_WIDE   = 2;
  localparam int unsigned A_QUEUE  = 3;
  localparam int unsigned A_ENABLE = 4;
  localparam int unsigned A_BANK   = 32;

  logic                         cfg_d;
  logic [NFILT-1:0]             style_d, wide_d, queue_d, enable_d;
  logic [NFILT-1:0][WORD_W-1:0] w1_d, w2_d;

  always_comb begin
    cfg_d    = cfg_q;
    style_d  = style_q;
    wide_d   = wide_q;
    queue_d  = queue_q;
    enable_d = enable_q;
    w1_d     = w1_q;
    w2_d     = w2_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL)) begin
        cfg_d = wr_data[0];
      end else if (cfg_q) begin
        if (wr_addr == ADDR_W'(A_STYLE))  style_d  = wr_data[NFILT-1:0];
        if (wr_addr == ADDR_W'(A_WIDE))   wide_d   = wr_data[NFILT-1:0];
        if (wr_addr == ADDR_W'(A_QUEUE))  queue_d  = wr_data[NFILT-1:0];
        if (wr_addr == ADDR_W'(A_ENABLE)) enable_d = wr_data[NFILT-1:0];
        for (int f = 0; f < NFILT; f++) begin
          if (wr_addr == ADDR_W'(A_BANK + 2*f))     w1_d[f] = wr_data;
          if (wr_addr == ADDR_W'(A_BANK + 2*f + 1)) w2_d[f] = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= 1'b1;
      style_q  <= '0;
      wide_q   <= '0;
      queue_q  <= '0;
      enable_q <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
    end else if (wr_en) begin
      cfg_q    <= cfg_d;
      style_q  <= style_d;
      wide_q   <= wide_d;
      queue_q  <= queue_d;
      enable_q <= enable_d;
      w1_q     <= w1_d;
      w2_q     <= w2_d;
    end
  end
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
  import can_flt_pkg::*;
(
  input  logic [WORD_W-1:0]      key_wide,
  input  logic [HALF_W-1:0]      key_narrow,
  input  logic [WORD_W-1:0]      w1,
  input  logic [WORD_W-1:0]      w2,
  input  logic                   style,
  input  logic                   wide,
  input  logic                   enable,
  output logic [ENTRIES_MAX-1:0] hit
);
  localparam logic [WORD_W-1:0] CMP_BITS = {{(WORD_W-1){1'b1}}, 1'b0};

  always_comb begin
    hit = '0;
    if (enable) begin
      if (wide) begin
        if (cmp_style_e'(style) == CMP_LIST) begin
          hit[0] = ((key_wide ^ w1) & CMP_BITS) == '0;
          hit[1] = ((key_wide ^ w2) & CMP_BITS) == '0;
        end else begin
          hit[0] = ((key_wide ^ w1) & w2 & CMP_BITS) == '0;
        end
      end else begin
        if (cmp_style_e'(style) == CMP_LIST) begin
          hit[0] = key_narrow == w1[HALF_W-1:0];
          hit[1] = key_narrow == w1[WORD_W-1:HALF_W];
          hit[2] = key_narrow == w2[HALF_W-1:0];
          hit[3] = key_narrow == w2[WORD_W-1:HALF_W];
        end else begin
          hit[0] = ((key_narrow ^ w1[HALF_W-1:0]) & w1[WORD_W-1:HALF_W]) == '0;
          hit[1] = ((key_narrow ^ w2[HALF_W-1:0]) & w2[WORD_W-1:HALF_W]) == '0;
        end
      end
    end
  end
endmodule

// File: rtl/can_flt_select.sv
module can_flt_select
  import can_flt_pkg::*;
#(
  parameter int unsigned NFILT = 14,
  parameter int unsigned IDX_W = 8
) (
  input  logic [NFILT-1:0][ENTRIES_MAX-1:0] hits,
  input  logic [NFILT-1:0]                  style,
  input  logic [NFILT-1:0]                  wide,
  input  logic [NFILT-1:0]                  queue,
  output logic                              found,
  output logic                              found_queue,
  output logic [IDX_W-1:0]                  found_index
);
  logic [NFILT:0][IDX_W-1:0] base;

  assign base[0] = '0;
  for (genvar f = 0; f < NFILT; f++) begin : g_base
    assign base[f+1] = base[f] + IDX_W'(entry_count(wide[f], style[f]));
  end

  // Scan from the top so that the lowest filter and entry are assigned last
  always_comb begin
    found       = 1'b0;
    found_queue = 1'b0;
    found_index = '0;
    for (int f = NFILT - 1; f >= 0; f--) begin
      for (int e = ENTRIES_MAX - 1; e >= 0; e--) begin
        if (hits[f][e]) begin
          found       = 1'b1;
          found_queue = queue[f];
          found_index = base[f] + IDX_W'(e);
        end
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int unsigned NFILT  = 14,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              frm_valid,
  input  logic [10:0]       frm_sid,
  input  logic [17:0]       frm_eid,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_fifo,
  output logic [IDX_W-1:0]  res_index
);
  logic                            cfg_q;
  logic [NFILT-1:0]                style_q, wide_q, queue_q, enable_q;
  logic [NFILT-1:0][WORD_W-1:0]    w1_q, w2_q;
  logic [NFILT-1:0][ENTRIES_MAX-1:0] hits;
  logic                            found, found_queue;
  logic [IDX_W-1:0]                found_index;
  frame_id_t                       fid;
  logic [WORD_W-1:0]               key_wide;
  logic [HALF_W-1:0]               key_narrow;

  logic             valid_d, accept_d, fifo_d;
  logic [IDX_W-1:0] index_d;

  can_flt_regs #(.NFILT(NFILT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_q(cfg_q), .style_q(style_q), .wide_q(wide_q), .queue_q(queue_q),
    .enable_q(enable_q), .w1_q(w1_q), .w2_q(w2_q)
  );

  assign fid        = '{sid: frm_sid, eid: frm_eid, ide: frm_ide, rtr: frm_rtr};
  assign key_wide   = pack_wide(fid);
  assign key_narrow = pack_narrow(fid);

  for (genvar f = 0; f < NFILT; f++) begin : g_filter
    can_flt_match u_match (
      .key_wide(key_wide), .key_narrow(key_narrow),
      .w1(w1_q[f]), .w2(w2_q[f]),
      .style(style_q[f]), .wide(wide_q[f]), .enable(enable_q[f]),
      .hit(hits[f])
    );
  end

  can_flt_select #(.NFILT(NFILT), .IDX_W(IDX_W)) u_sel (
    .hits(hits), .style(style_q), .wide(wide_q), .queue(queue_q),
    .found(found), .found_queue(found_queue), .found_index(found_index)
  );

  always_comb begin
    valid_d  = frm_valid;
    accept_d = frm_valid && !cfg_q && found;
    fifo_d   = accept_d ? found_queue : 1'b0;
    index_d  = accept_d ? found_index : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_fifo   <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= valid_d;
      res_accept <= accept_d;
      res_fifo   <= fifo_d;
      res_index  <= index_d;
    end
  end
endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk #(
  parameter int unsigned NFILT = 14,
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             cfg_q,
  input logic [NFILT-1:0] enable_q,
  input logic             res_valid,
  input logic             res_accept,
  input logic             res_fifo,
  input logic [IDX_W-1:0] res_index
);
  p_result_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);
  p_no_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid);
  p_accept_has_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);
  p_cfg_rejects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_q) |=> !res_accept);
  p_none_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && enable_q == '0) |=> !res_accept);
  p_reject_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (res_index == '0 && !res_fifo));
  p_index_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> (res_index < IDX_W'(4*NFILT)));
endmodule

bind can_accept_filter can_flt_chk #(.NFILT(NFILT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .cfg_q(cfg_q),
  .enable_q(enable_q), .res_valid(res_valid), .res_accept(res_accept),
  .res_fifo(res_fifo), .res_index(res_index)
);

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
  localparam int NF = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        frm_valid = 1'b0;
  logic [10:0] frm_sid = '0;
  logic [17:0] frm_eid = '0;
  logic        frm_ide = 1'b0;
  logic        frm_rtr = 1'b0;
  logic        res_valid, res_accept, res_fifo;
  logic [7:0]  res_index;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  bit      m_cfg;
  bit [NF-1:0] m_style, m_wide, m_queue, m_en;
  bit [31:0] m_w1 [NF];
  bit [31:0] m_w2 [NF];

  always #2 clk = ~clk;

  can_accept_filter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frm_valid(frm_valid), .frm_sid(frm_sid), .frm_eid(frm_eid), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .res_valid(res_valid), .res_accept(res_accept),
    .res_fifo(res_fifo), .res_index(res_index)
  );

  function automatic bit [31:0] mk32(int sid, int eid, bit ide, bit rtr);
    return (32'(sid) << 21) | (32'(eid) << 3) | (32'(ide) << 2) | (32'(rtr) << 1);
  endfunction

  function automatic bit [15:0] mk16(int sid, bit rtr, bit ide, int eidh);
    return 16'((sid << 5) | (int'(rtr) << 4) | (int'(ide) << 3) | (eidh & 7));
  endfunction

  function automatic void model_eval(output bit acc, output bit q, output int idx);
    bit [31:0] k32, id, mk;
    int base, n;
    bit wide, list;
    k32 = mk32(frm_sid, frm_eid, frm_ide, frm_rtr);
    acc = 0; q = 0; idx = 0; base = 0;
    for (int f = 0; f < NF; f++) begin
      wide = m_wide[f]; list = m_style[f];
      n = wide ? (list ? 2 : 1) : (list ? 4 : 2);
      for (int e = 0; e < n; e++) begin
        if (wide) begin
          id = (list && e == 1) ? m_w2[f] : m_w1[f];
          mk = list ? 32'hFFFF_FFFE : (m_w2[f] & 32'hFFFF_FFFE);
          if (!acc && m_en[f] && ((k32 ^ id) & mk) == 0) begin
            acc = 1; q = m_queue[f]; idx = base + e;
          end
        end else begin
          bit [31:0] src;
          bit [15:0] k16;
          k16 = mk16(frm_sid, frm_rtr, frm_ide, frm_eid >> 15);
          if (list) begin
            src = (e < 2) ? m_w1[f] : m_w2[f];
            id = (e % 2 == 1) ? (src >> 16) : (src & 32'hFFFF);
            mk = 32'hFFFF;
          end else begin
            src = (e == 0) ? m_w1[f] : m_w2[f];
            id = src & 32'hFFFF; mk = src >> 16;
          end
          if (!acc && m_en[f] && ((32'(k16) ^ id) & mk) == 0) begin
            acc = 1; q = m_queue[f]; idx = base + e;
          end
        end
      end
      base += n;
    end
    if (m_cfg || !frm_valid) begin acc = 0; q = 0; idx = 0; end
  endfunction

  task automatic step();
    bit ea, eq, ev;
    int ei;
    ev = frm_valid;
    model_eval(ea, eq, ei);
    if (wr_en) begin
      if (wr_addr == 0) m_cfg = wr_data[0];
      else if (m_cfg) begin
        case (int'(wr_addr))
          1: m_style = wr_data[NF-1:0];
          2: m_wide  = wr_data[NF-1:0];
          3: m_queue = wr_data[NF-1:0];
          4: m_en    = wr_data[NF-1:0];
          default: if (wr_addr >= 32 && wr_addr < 32 + 2*NF) begin
            if (wr_addr[0]) m_w2[(int'(wr_addr) - 32) / 2] = wr_data;
            else            m_w1[(int'(wr_addr) - 32) / 2] = wr_data;
          end
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (res_valid !== ev || res_accept !== ea || res_fifo !== eq || res_index !== 8'(ei)) begin
      n_errors++;
      $display("FAIL %s: got v=%0b a=%0b q=%0b idx=%0d, expected v=%0b a=%0b q=%0b idx=%0d",
               tag, res_valid, res_accept, res_fifo, res_index, ev, ea, eq, ei);
    end
  endtask

  task automatic wr(int a, bit [31:0] d);
    wr_en = 1; wr_addr = 6'(a); wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic frame(int sid, int eid, bit ide, bit rtr, string t);
    tag = t;
    frm_valid = 1; frm_sid = 11'(sid); frm_eid = 18'(eid); frm_ide = ide; frm_rtr = rtr;
    step();
    frm_valid = 0;
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_sim();
  end

  initial begin
    m_cfg = 1; m_style = 0; m_wide = 0; m_queue = 0; m_en = 0;
    for (int f = 0; f < NF; f++) begin m_w1[f] = 0; m_w2[f] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    n_checks++;
    if (res_valid !== 0 || res_accept !== 0 || res_fifo !== 0 || res_index !== 0) begin
      n_errors++;
      $display("FAIL R1: got v=%0b a=%0b q=%0b idx=%0d, expected all 0",
               res_valid, res_accept, res_fifo, res_index);
    end
    rst_n = 1;
    tag = "R1"; step();

    // Configure bank; configure bit is 1 out of reset (R1, R2)
    tag = "R2";
    wr(32, mk32(11'h123, 0, 0, 0));                 // f0: 32-bit mask
    wr(33, mk32(11'h7FF, 0, 1, 0));
    wr(34, mk32(11'h5A5, 18'h1234, 1, 0));          // f1: 32-bit list
    wr(35, mk32(11'h0F0, 18'h3ABCD, 1, 1));
    wr(36, {mk16(11'h7F0, 1, 1, 0), mk16(11'h300, 0, 0, 0)}); // f2: 16-bit mask
    wr(37, {16'hFFFF, mk16(11'h400, 0, 0, 0)});
    wr(38, {mk16(11'h301, 0, 0, 0), mk16(11'h111, 0, 0, 0)}); // f3: 16-bit list
    wr(39, {mk16(11'h222, 1, 0, 0), mk16(11'h333, 0, 0, 0)});
    wr(40, 32'h0); wr(41, 32'h0);                   // f4: catch-all, disabled
    wr(58, 32'h0); wr(59, 32'h0);                   // f13: catch-all
    wr(1, 32'b1010);
    wr(2, (32'h1 << 13) | 32'b10011);
    wr(3, (32'h1 << 13) | 32'b10);
    wr(4, (32'h1 << 13) | 32'b1111);

    frame(11'h123, 0, 0, 0, "R2");                  // rejected while configuring
    wr(0, 0);

    frame(11'h123, 0, 0, 0, "R4");                  // f0, idx 0
    frame(11'h123, 18'h2AAAA, 0, 1, "R4");          // unmasked bits differ
    frame(11'h124, 0, 0, 0, "R4");                  // falls to f13
    frame(11'h123, 0, 1, 0, "R4");                  // IDE masked -> f13
    frame(11'h0F0, 18'h3ABCD, 1, 1, "R5");          // f1 entry 1, queue 1 (R9)
    frame(11'h5A5, 18'h1234, 1, 0, "R9");           // f1 entry 0
    frame(11'h5A5, 18'h1234, 1, 1, "R5");           // RTR differs -> f13
    frame(11'h30C, 0, 0, 0, "R6");                  // f2 entry 0
    frame(11'h400, 0, 0, 0, "R6");                  // f2 entry 1
    frame(11'h400, 18'h08000, 1, 0, "R6");          // narrow bits differ -> f13
    frame(11'h111, 0, 0, 0, "R7");
    frame(11'h333, 0, 0, 0, "R7");
    frame(11'h222, 0, 0, 1, "R7");                  // f3 entry 3
    frame(11'h301, 0, 0, 0, "R8");                  // f2 beats f3

    // R2: writes outside configure mode ignored
    wr(32, mk32(11'h555, 0, 0, 0));
    wr(4, 32'h0);
    frame(11'h123, 0, 0, 0, "R2");

    // R3: only disabled catch-all left
    wr(0, 1);
    wr(4, 32'b1111);
    wr(0, 0);
    frame(11'h6AB, 18'h11111, 1, 0, "R3");
    frame(11'h123, 0, 0, 0, "R4");

    // mixed stream with idle gaps (R10)
    for (int i = 0; i < 200; i++) begin
      if (i % 3 == 0) begin tag = "R10"; step(); end
      else frame((i * 37) & 11'h7FF, (i * 911) & 18'h3FFFF, i[0], i[1], "R8");
    end
    repeat (4) begin tag = "R10"; step(); end
    finish_sim();
  end
endmodule